// File: doc/BRIEF.md
# LFO Amplitude Modulation Unit

This block turns a slow free-running oscillator counter into the tremolo term that an FM operator adds to its attenuation. A 7-bit counter advances by one each time the rate logic pulses a step strobe, wrapping after 128 positions. The count is folded into a triangle whose first half runs downward, so position 0 is the point of deepest attenuation. The triangle is doubled, scaled down by a 2-bit depth setting and passed to the operator only when that operator has tremolo switched on.

When the oscillator is switched off, the counter is forced to 0 and held there. Because 0 is the peak of the folded wave, a disabled oscillator still applies a fixed attenuation at full depth rather than none. The raw count is also exported for other modulation consumers.

Top module: `lfo_am_unit`

## Requirements
- R1: While `rst_n` is low the counter reads 0, and it stays 0 at the first clock edge after reset is released unless a step is requested.
- R2: With `lfo_run` high, each clock edge at which `lfo_step` is high increments `lfo_count` by one.
- R3: The counter wraps from 127 to 0 on a step.
- R4: With `lfo_run` high and `lfo_step` low, `lfo_count` keeps its value.
- R5: With `lfo_run` low, `lfo_count` becomes 0 at the next edge whatever `lfo_step` is; after `lfo_run` returns high, counting resumes from 0 at the next step.
- R6: The wave value is the low 6 count bits, bitwise inverted when count bit 6 is 0 and taken as is when bit 6 is 1, then doubled; its range is 0 to 126.
- R7: `depth_sel` values 0, 1, 2, 3 shift the wave value right by 8, 3, 1 and 0 bits, so depth 0 always gives an offset of 0.
- R8: `am_atten` is 0 whenever `trem_on` is low, for any count and depth.
- R9: While the oscillator is off, `trem_on` high and `depth_sel` = 3 give a fixed offset of 126.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lfo_run | input | 1 | Oscillator enable; low forces the counter to 0 |
| lfo_step | input | 1 | One-cycle advance request from the rate logic |
| depth_sel | input | 2 | Tremolo depth setting |
| trem_on | input | 1 | Operator's tremolo enable |
| lfo_count | output | 7 | Current oscillator count |
| am_atten | output | 7 | Attenuation offset for the operator |

## Verification
The hardest condition to reach is the upper half of the wave and the 127-to-0 wrap. Both need a long unbroken run of steps with the oscillator enabled, and random toggling of `lfo_run` keeps clearing the count long before it gets there. The stimulus therefore starts with a directed run of 130 consecutive steps that sweeps every count value at full depth. It then gives random traffic in which `lfo_run` is low only rarely, so that both halves of the fold are visited under all four depths and both tremolo settings.

// File: rtl/lfo_am_pkg.sv
// Shared constants and the depth-to-shift mapping for the LFO tremolo unit.
// Assumes a 2-bit depth code; the shift table is part of the behaviour.
package lfo_am_pkg;
    localparam int LFO_CNT_W = 7;

    // Right-shift amount applied to the doubled wave for each depth code.
    function automatic int unsigned depth_shift(input logic [1:0] code);
        case (code)
            2'd0:    return 8;
            2'd1:    return 3;
            2'd2:    return 1;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/lfo_step_counter.sv
// Free-running oscillator counter that advances on a strobe and wraps.
// Assumes the strobe is one cycle wide; a low run input clears and holds at 0.
module lfo_step_counter #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    output logic [CNT_W-1:0] count
);
    // Count update: reset and disable force 0, a step advances by one.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            count <= '0;
        end else if (step) begin
            count <= count + CNT_W'(1);
        end
    end
endmodule

// File: rtl/lfo_tri_shaper.sv
// Folds the counter into a doubled triangle that starts at its peak.
// Assumes the top count bit selects the half of the wave.
module lfo_tri_shaper #(
    parameter int CNT_W = 7
) (
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] wave
);
    localparam int HALF_W = CNT_W - 1;

    logic [HALF_W-1:0] folded;

    // Fold: the falling half inverts the low bits, the rising half passes them.
    always_comb begin
        if (count[CNT_W-1]) folded = count[HALF_W-1:0];
        else                folded = ~count[HALF_W-1:0];
        wave = {folded, 1'b0};
    end
endmodule

// File: rtl/lfo_depth_scaler.sv
// Scales the wave down by the shift chosen for each depth code.
// Assumes four depth codes; each candidate shift is built in its own slice.
module lfo_depth_scaler #(
    parameter int W = 7
) (
    input  logic [W-1:0] wave,
    input  logic [1:0]   depth,
    output logic [W-1:0] scaled
);
    import lfo_am_pkg::*;

    localparam int N_DEPTH = 4;

    logic [W-1:0] cand [N_DEPTH];

    for (genvar g = 0; g < N_DEPTH; g++) begin : g_shift
        localparam int SH = int'(depth_shift(2'(g)));
        if (SH >= W) begin : g_zero
            assign cand[g] = '0;
        end else begin : g_sh
            assign cand[g] = wave >> SH;
        end
    end

    // Select the candidate for the current depth code.
    always_comb scaled = cand[depth];
endmodule

// File: rtl/lfo_am_unit.sv
// Top of the LFO tremolo path: counter, triangle fold, depth scaling, gate.
// Assumes the step strobe comes from separate rate logic.
module lfo_am_unit #(
    parameter int CNT_W = lfo_am_pkg::LFO_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lfo_run,
    input  logic             lfo_step,
    input  logic [1:0]       depth_sel,
    input  logic             trem_on,
    output logic [CNT_W-1:0] lfo_count,
    output logic [CNT_W-1:0] am_atten
);
    logic [CNT_W-1:0] wave;
    logic [CNT_W-1:0] scaled;

    lfo_step_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .run(lfo_run), .step(lfo_step), .count(lfo_count)
    );

    lfo_tri_shaper #(.CNT_W(CNT_W)) shp_i (
        .count(lfo_count), .wave(wave)
    );

    lfo_depth_scaler #(.W(CNT_W)) scl_i (
        .wave(wave), .depth(depth_sel), .scaled(scaled)
    );

    // Gate: only operators with tremolo enabled receive the offset.
    always_comb am_atten = trem_on ? scaled : '0;
endmodule

// File: rtl/lfo_am_unit_chk.sv
// Checker for the tremolo unit, attached by bind. Observes ports only.
module lfo_am_unit_chk #(
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lfo_run,
    input logic             lfo_step,
    input logic [1:0]       depth_sel,
    input logic             trem_on,
    input logic [CNT_W-1:0] lfo_count,
    input logic [CNT_W-1:0] am_atten
);
    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lfo_run && lfo_step) |=> lfo_count == CNT_W'($past(lfo_count) + 1'b1));

    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lfo_run && lfo_step && (&lfo_count)) |=> lfo_count == '0);

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lfo_run && !lfo_step) |=> $stable(lfo_count));

    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !lfo_run |=> lfo_count == '0);

    assert_depth0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (depth_sel == 2'd0) |-> am_atten == '0);

    assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !trem_on |-> am_atten == '0);

    assert_peak_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lfo_count == '0 && trem_on && depth_sel == 2'd3) |-> am_atten == CNT_W'(126));
endmodule

bind lfo_am_unit lfo_am_unit_chk #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .lfo_run(lfo_run), .lfo_step(lfo_step),
    .depth_sel(depth_sel), .trem_on(trem_on), .lfo_count(lfo_count), .am_atten(am_atten)
);

// File: tb/lfo_am_unit_tb_top.sv
`timescale 1ns/1ps
module lfo_am_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lfo_run = 1'b0;
    logic       lfo_step = 1'b0;
    logic [1:0] depth_sel = 2'd3;
    logic       trem_on = 1'b1;
    logic [6:0] lfo_count;
    logic [6:0] am_atten;

    int checks = 0;
    int errors = 0;
    logic [6:0] mcnt = 7'd0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lfo_am_unit dut_i (
        .clk(clk), .rst_n(rst_n), .lfo_run(lfo_run), .lfo_step(lfo_step),
        .depth_sel(depth_sel), .trem_on(trem_on), .lfo_count(lfo_count), .am_atten(am_atten)
    );

    // Expected offset computed from R6, R7, R8.
    function automatic logic [6:0] exp_atten(input logic [6:0] c, input logic [1:0] d, input logic en);
        logic [5:0] f;
        logic [6:0] w;
        int sh;
        f = c[6] ? c[5:0] : ~c[5:0];
        w = {f, 1'b0};
        sh = (d == 2'd0) ? 8 : (d == 2'd1) ? 3 : (d == 2'd2) ? 1 : 0;
        if (!en) return 7'd0;
        return (sh >= 7) ? 7'd0 : (w >> sh);
    endfunction

    task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // At the falling edge: compare, drive next inputs, advance the model.
    task automatic cyc(input string req, input logic run, input logic stb,
                       input logic [1:0] d, input logic en);
        @(negedge clk);
        check({req, " count"}, lfo_count, mcnt);
        check({req, " atten"}, am_atten, exp_atten(mcnt, depth_sel, trem_on));
        lfo_run = run; lfo_step = stb; depth_sel = d; trem_on = en;
        if (!rst_n || !run) mcnt = 7'd0;
        else if (stb) mcnt = mcnt + 7'd1;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned r;
        r = $urandom(32'd2612);
        // R1: reset state, with strobes driven during reset
        cyc("R1", 1'b1, 1'b1, 2'd3, 1'b1);
        cyc("R1", 1'b1, 1'b1, 2'd3, 1'b1);
        @(negedge clk);
        check("R1 reset count", lfo_count, 7'd0);
        check("R9 reset peak", am_atten, 7'd126);
        rst_n = 1'b1;
        lfo_step = 1'b0;
        mcnt = 7'd0;
        cyc("R1", 1'b1, 1'b0, 2'd3, 1'b1);
        // R2 R3 R6: sweep every count and wrap
        for (int i = 0; i < 130; i++) cyc("R2R3R6", 1'b1, 1'b1, 2'd3, 1'b1);
        // R4: hold
        for (int i = 0; i < 5; i++) cyc("R4", 1'b1, 1'b0, 2'd3, 1'b1);
        // R7: each depth at the peak of the rising half (count 127)
        while (mcnt != 7'd127) cyc("R7", 1'b1, 1'b1, 2'd3, 1'b1);
        for (int d = 0; d < 4; d++) cyc("R7", 1'b1, 1'b0, 2'(d), 1'b1);
        // R8: gate off at a non-zero wave
        cyc("R8", 1'b1, 1'b0, 2'd3, 1'b0);
        cyc("R8", 1'b1, 1'b0, 2'd3, 1'b0);
        // R5 R9: disable with strobe, peak fixed
        for (int i = 0; i < 4; i++) cyc("R5R9", 1'b0, 1'b1, 2'd3, 1'b1);
        @(negedge clk);
        check("R9 disabled peak", am_atten, 7'd126);
        check("R5 cleared", lfo_count, 7'd0);
        // R5: resume from 0
        cyc("R5", 1'b1, 1'b0, 2'd3, 1'b1);
        cyc("R5", 1'b1, 1'b1, 2'd2, 1'b1);
        cyc("R5", 1'b1, 1'b0, 2'd2, 1'b1);
        @(negedge clk);
        check("R5 resume", lfo_count, 7'd1);
        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            cyc("RND", ($urandom % 40) != 0, ($urandom % 3) != 0,
                2'($urandom % 4), ($urandom % 4) != 0);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule